// File: doc/BRIEF.md
# Shared-Pool Non-Posted Request Tag Allocator

This block hands out and reclaims transaction tags for outstanding non-posted requests on a PCIe link. All physical and virtual functions draw from one common pool. Two tag classes live in that pool. Narrow tags take values below 256. Wide tags take values from 256 up to 767. A requester presents its function number. The allocator then grants a wide tag if wide tagging is switched on for the port and for that function; otherwise it grants a narrow tag.

A 256-bit configuration mask assigns each low-byte value to exactly one class. A low byte whose mask bit is set belongs to the narrow class. Every other low byte is usable only by the wide class, in both of its upper ranges. Because of this split, a live narrow tag can never share its low 8 bits with a live wide tag. A release port on the completion side returns tags to the pool. A release that names a tag which is not held is ignored and raises a sticky error flag. Two outputs give the number of tags currently held in each class.

Top module: `np_tag_alloc`

## Requirements
- R1: A request gets a wide tag (grant_is10 = 1) exactly when tag10_port_en is 1 and fn_tag10_en[req_fn] is 1. Otherwise it gets a narrow tag (grant_is10 = 0).
- R2: A narrow grant is the lowest value t in 0..255 such that class8_mask[t] = 1 and t is not held.
- R3: A wide grant is the lowest value t in 256..767 such that class8_mask[t mod 256] = 0 and t is not held.
- R4: req_ready is 1 exactly when the requested class has at least one eligible free tag. A tag is taken only in a cycle where req_valid and req_ready are both 1.
- R5: A granted tag is never granted again while it is held.
- R6: A release of a held tag frees it. The freed tag can be granted from the cycle after the release, but not in the release cycle.
- R7: A release whose tag is not held, or whose value exceeds 767, changes no held state and no counter. It sets rel_err, which stays 1 until reset.
- R8: cnt8 counts held tags below 256 and cnt10 counts held tags from 256 up. Both counters stay correct when a grant and a release happen in the same cycle.
- R9: After reset every tag is free, both counters are zero and rel_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tag10_port_en | input | 1 | Wide tag capability switched on for the port |
| fn_tag10_en | input | NUM_FN | Per-function wide tag request enable |
| class8_mask | input | 256 | Set bit: that low-byte value belongs to the narrow class |
| req_valid | input | 1 | Tag request |
| req_fn | input | $clog2(NUM_FN) | Function number of the request |
| req_ready | output | 1 | A tag of the requested class is available |
| grant_tag | output | 10 | Tag granted when req_valid and req_ready |
| grant_is10 | output | 1 | Granted tag is from the wide class |
| rel_valid | input | 1 | Tag release |
| rel_tag | input | 10 | Tag being released |
| rel_err | output | 1 | Sticky flag: a release named a tag that was not held |
| cnt8 | output | 9 | Narrow tags held |
| cnt10 | output | 10 | Wide tags held |

## Verification
A directed opening uses a mask that gives the first 64 low bytes to the narrow class. It checks that the first wide grant skips to 320. It checks that a tag released in the same cycle as a grant is handed out only on the next request. It checks that double releases and out-of-range releases set the error flag without touching the counters. Filling the narrow class until ready drops tells apart correct exhaustion from a picker that wanders into masked low bytes. Turning off the port capability shows that a function with its own enable set still falls back to the narrow class. A long random phase mixes all functions, valid and bogus releases, and a mid-run mask change while tags are held. A cycle-level reference model follows every grant, count and flag during this phase.

// File: rtl/np_tag_pkg.sv
package np_tag_pkg;
    localparam int LOW_W   = 8;
    localparam int N_LOW   = 1 << LOW_W;
    localparam int N8      = N_LOW;
    localparam int N10     = 2 * N_LOW;
    localparam int N_TAG   = N8 + N10;
    localparam int TAG_W   = 10;
    localparam int CNT8_W  = $clog2(N8) + 1;
    localparam int CNT10_W = $clog2(N10) + 1;

    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic [N_TAG-1:0]   busy;
        logic [CNT8_W-1:0]  cnt8;
        logic [CNT10_W-1:0] cnt10;
        logic               err;
    } alloc_st_t;
endpackage

// File: rtl/np_tag_elig.sv
module np_tag_elig
    import np_tag_pkg::*;
(
    input  logic [N_TAG-1:0] busy,
    input  logic [N_LOW-1:0] class8_mask,
    output logic [N8-1:0]    free8,
    output logic [N10-1:0]   free10
);
    for (genvar g = 0; g < N8; g++) begin : g_narrow
        assign free8[g] = class8_mask[g] & ~busy[g];
    end

    for (genvar g = 0; g < N10; g++) begin : g_wide
        assign free10[g] = ~class8_mask[g % N_LOW] & ~busy[N8 + g];
    end
endmodule

// File: rtl/np_tag_pick.sv
module np_tag_pick #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i] && !found) begin
                found = 1'b1;
                idx   = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/np_tag_alloc.sv
module np_tag_alloc
    import np_tag_pkg::*;
#(
    parameter int NUM_FN = 8,
    parameter int FN_W   = $clog2(NUM_FN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tag10_port_en,
    input  logic [NUM_FN-1:0]   fn_tag10_en,
    input  logic [N_LOW-1:0]    class8_mask,
    input  logic                req_valid,
    input  logic [FN_W-1:0]     req_fn,
    output logic                req_ready,
    output logic [TAG_W-1:0]    grant_tag,
    output logic                grant_is10,
    input  logic                rel_valid,
    input  logic [TAG_W-1:0]    rel_tag,
    output logic                rel_err,
    output logic [CNT8_W-1:0]   cnt8,
    output logic [CNT10_W-1:0]  cnt10
);
    localparam int IDX8_W  = $clog2(N8);
    localparam int IDX10_W = $clog2(N10);

    alloc_st_t st_q, st_d;

    logic [N8-1:0]      free8;
    logic [N10-1:0]     free10;
    logic               found8, found10;
    logic [IDX8_W-1:0]  idx8;
    logic [IDX10_W-1:0] idx10;
    logic               want10;
    logic               fire;
    logic               rel_in_range;
    logic               rel_hit;

    np_tag_elig u_elig (
        .busy        (st_q.busy),
        .class8_mask (class8_mask),
        .free8       (free8),
        .free10      (free10)
    );

    np_tag_pick #(.W(N8)) u_pick8 (
        .vec   (free8),
        .found (found8),
        .idx   (idx8)
    );

    np_tag_pick #(.W(N10)) u_pick10 (
        .vec   (free10),
        .found (found10),
        .idx   (idx10)
    );

    assign want10     = tag10_port_en & fn_tag10_en[req_fn];
    assign req_ready  = want10 ? found10 : found8;
    assign grant_is10 = want10;
    assign grant_tag  = want10 ? (tag_t'(idx10) + tag_t'(N8)) : tag_t'(idx8);
    assign fire       = req_valid & req_ready;

    assign rel_in_range = rel_tag < tag_t'(N_TAG);
    assign rel_hit      = rel_valid & rel_in_range & st_q.busy[rel_tag];

    always_comb begin
        st_d = st_q;
        if (rel_hit) begin
            st_d.busy[rel_tag] = 1'b0;
            if (rel_tag < tag_t'(N8)) begin
                st_d.cnt8 = st_d.cnt8 - CNT8_W'(1);
            end else begin
                st_d.cnt10 = st_d.cnt10 - CNT10_W'(1);
            end
        end else if (rel_valid) begin
            st_d.err = 1'b1;
        end
        if (fire) begin
            st_d.busy[grant_tag] = 1'b1;
            if (want10) begin
                st_d.cnt10 = st_d.cnt10 + CNT10_W'(1);
            end else begin
                st_d.cnt8 = st_d.cnt8 + CNT8_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rel_err = st_q.err;
    assign cnt8    = st_q.cnt8;
    assign cnt10   = st_q.cnt10;
endmodule

// File: rtl/np_tag_chk.sv
module np_tag_chk
    import np_tag_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [N_LOW-1:0]   class8_mask,
    input logic               req_valid,
    input logic               req_ready,
    input logic [TAG_W-1:0]   grant_tag,
    input logic               grant_is10,
    input logic               rel_valid,
    input logic [TAG_W-1:0]   rel_tag,
    input logic               rel_err,
    input logic [CNT8_W-1:0]  cnt8
);
    logic fire;
    assign fire = req_valid & req_ready;

    p_grant8_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !grant_is10 |-> grant_tag < 10'd256 && class8_mask[grant_tag[7:0]]);

    p_grant10_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire && grant_is10 |-> grant_tag >= 10'd256 && grant_tag < 10'd768
                               && !class8_mask[grant_tag[7:0]]);

    p_no_regrant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !(req_valid && req_ready && grant_tag == $past(grant_tag)));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err |=> rel_err);

    p_err_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && rel_tag >= 10'd768 |=> rel_err);

    p_cnt8_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !grant_is10 && !rel_valid |=> cnt8 == $past(cnt8) + CNT8_W'(1));
endmodule

bind np_tag_alloc np_tag_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .class8_mask (class8_mask),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .grant_tag   (grant_tag),
    .grant_is10  (grant_is10),
    .rel_valid   (rel_valid),
    .rel_tag     (rel_tag),
    .rel_err     (rel_err),
    .cnt8        (cnt8)
);

// File: tb/np_tag_alloc_tb.sv
`timescale 1ns/1ps
module np_tag_alloc_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tag10_port_en = 1'b1;
    logic [7:0]   fn_tag10_en = 8'b0000_0101;
    logic [255:0] class8_mask = '0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_fn = '0;
    logic         req_ready;
    logic [9:0]   grant_tag;
    logic         grant_is10;
    logic         rel_valid = 1'b0;
    logic [9:0]   rel_tag = '0;
    logic         rel_err;
    logic [8:0]   cnt8;
    logic [9:0]   cnt10;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  m_busy [0:767];
    int  m_cnt8 = 0;
    int  m_cnt10 = 0;
    bit  m_err = 0;
    int  last_tag;
    bit  last_rdy;

    always #5 clk = ~clk;

    np_tag_alloc dut_i (
        .clk(clk), .rst_n(rst_n), .tag10_port_en(tag10_port_en),
        .fn_tag10_en(fn_tag10_en), .class8_mask(class8_mask),
        .req_valid(req_valid), .req_fn(req_fn), .req_ready(req_ready),
        .grant_tag(grant_tag), .grant_is10(grant_is10),
        .rel_valid(rel_valid), .rel_tag(rel_tag), .rel_err(rel_err),
        .cnt8(cnt8), .cnt10(cnt10)
    );

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
        end
    endtask

    function automatic int find_free(input bit wide);
        if (wide) begin
            for (int t = 256; t < 768; t++)
                if (!class8_mask[t % 256] && !m_busy[t]) return t;
        end else begin
            for (int t = 0; t < 256; t++)
                if (class8_mask[t] && !m_busy[t]) return t;
        end
        return -1;
    endfunction

    task automatic step(input bit rv, input int fn, input bit relv, input int rtag);
        bit wide;
        int exp_t;
        req_valid = rv;
        req_fn    = fn[2:0];
        rel_valid = relv;
        rel_tag   = rtag[9:0];
        #1;
        wide  = tag10_port_en && fn_tag10_en[fn];
        exp_t = find_free(wide);
        chk("R1", int'(grant_is10), int'(wide));
        chk("R4", int'(req_ready), int'(exp_t >= 0));
        if (exp_t >= 0) chk(wide ? "R3" : "R2", int'(grant_tag), exp_t);
        chk("R8", int'(cnt8), m_cnt8);
        chk("R8", int'(cnt10), m_cnt10);
        chk("R7", int'(rel_err), int'(m_err));
        last_tag = int'(grant_tag);
        last_rdy = req_ready;
        @(posedge clk);
        if (relv) begin
            if (rtag < 768 && m_busy[rtag]) begin
                m_busy[rtag] = 0;
                if (rtag < 256) m_cnt8--; else m_cnt10--;
            end else begin
                m_err = 1;
            end
        end
        if (rv && exp_t >= 0) begin
            m_busy[exp_t] = 1;
            if (exp_t < 256) m_cnt8++; else m_cnt10++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R9: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int a;
        for (int i = 0; i < 768; i++) m_busy[i] = 0;
        class8_mask = {192'b0, 64'hFFFF_FFFF_FFFF_FFFF};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9", int'(cnt8), 0);
        chk("R9", int'(cnt10), 0);
        chk("R9", int'(rel_err), 0);
        chk("R9", int'(req_ready), 1);
        @(negedge clk);

        repeat (4) step(1, 1, 0, 0);
        chk("R2", last_tag, 3);
        step(1, 0, 0, 0);
        chk("R3", last_tag, 320);
        step(1, 1, 1, 1);
        chk("R6", last_tag, 4);
        step(1, 1, 0, 0);
        chk("R6", last_tag, 1);
        step(0, 0, 1, 2);
        chk("R8", int'(cnt8), 4);
        step(0, 0, 1, 2);
        chk("R7", int'(rel_err), 1);
        chk("R7", int'(cnt8), 4);
        step(0, 0, 1, 800);
        chk("R7", int'(cnt10), 1);
        step(1, 1, 0, 0);
        a = last_tag;
        step(1, 1, 0, 0);
        chk("R5", int'(a != last_tag), 1);

        repeat (70) step(1, 1, 0, 0);
        #1;
        chk("R4", int'(req_ready), 0);
        chk("R8", int'(cnt8), 64);
        tag10_port_en = 1'b0;
        req_fn = 3'd0;
        #1;
        chk("R1", int'(grant_is10), 0);
        chk("R4", int'(req_ready), 0);
        step(0, 0, 0, 0);
        tag10_port_en = 1'b1;
        step(0, 0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            bit rv, relv;
            int rt;
            if (i == 1500) begin
                for (int k = 0; k < 8; k++) class8_mask[k*32 +: 32] = $urandom;
            end
            rv   = ($urandom_range(0, 9) < 7);
            relv = ($urandom_range(0, 9) < 4);
            rt   = $urandom_range(0, 767);
            if ($urandom_range(0, 19) == 0) begin
                rt = $urandom_range(0, 1023);
            end else begin
                for (int k = 0; k < 768; k++) begin
                    if (m_busy[(rt + k) % 768]) begin
                        rt = (rt + k) % 768;
                        break;
                    end
                end
            end
            step(rv, $urandom_range(0, 7), relv, rt);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule